// File: doc/BRIEF.md
# Sixteen-Bit Parallel Prefix Adder

This block adds two unsigned 16-bit operands and a carry-in in purely combinational logic and returns a 16-bit sum and a carry-out. It fits a datapath slot where a ripple chain is too slow and a full lookahead expansion would cost too much fan-out. Every bit carry comes from a logarithmic-depth prefix network.

Each bit position first produces a generate/propagate pair. The carry-in enters as a virtual stage below bit 0 that generates the carry-in and never propagates. The pairs are merged by one associative combine cell, `(g,p) o (g',p') = (g | p&g', p&p')`. An up-sweep reduction tree pairs neighbours, then pairs of pairs, and so on. It leaves the whole-word group term at the top position and partial group terms at the other power-of-two boundaries. An inverse down-sweep tree then fills in every remaining intermediate carry. Each sum bit is the bit's propagate XOR the carry into that bit.

Top module: `bk_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, read as unsigned integers, for every input combination.
- R2: `cout_o` equals bit 16 of the 17-bit result of `a_i + b_i + cin_i`.
- R3: `cin_i` acts as the carry into bit 0. With `a_i = b_i = 0` and `cin_i = 1`, `sum_o` is 16'h0001 and `cout_o` is 0.
- R4: When every bit propagates (`b_i == ~a_i`), `cin_i` travels the full width. `cout_o` equals `cin_i`, and `sum_o` is 16'h0000 for `cin_i = 1` or 16'hFFFF for `cin_i = 0`.
- R5: When bit 15 of both operands is set, `cout_o` is 1. For example, `a_i = b_i = 16'h8000` with `cin_i = 0` gives `sum_o = 0` and `cout_o = 1`.
- R6: A carry out of any position i needs bit i either to generate or to propagate. A carry generated at bit 0 reaches bit 15 through a run of propagating bits: `16'hFFFF + 16'h0001` gives `sum_o = 0` and `cout_o = 1`.
- R7: The outputs are a pure function of the present inputs, with no storage. A result is correct in the same cycle its inputs are applied, whatever the previous inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First addend |
| b_i | input | 16 | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The bench targets the following corner cases:

- **Carry-in folding.** A design that loses or misplaces the virtual stage below bit 0 returns a wrong low bit for 0+0+1, and the long propagate chains then fail everywhere.
- **Full-width propagation.** The all-propagate operands (`b = ~a`) expose a down-sweep that skips a level: some middle carry stays 0, so a run of sum bits comes out as ones where zeros are expected.
- **Skipped down-sweep nodes.** Exhaustive byte-slice patterns go through every fill-in node, and in the upper slice the carry crosses the byte boundary. A wrongly indexed partner in either tree shows up as sum bits that are wrong only for specific operand pairs.
- **Operator errors.** Random full-width vectors with both carry-in values catch a swapped operand order in the non-commutative combine cell and a wrong propagate-AND.

// File: rtl/bk_adder_pkg.sv
package bk_adder_pkg;
  // Associative prefix combine: {g, p} of (hi o lo)
  function automatic logic [1:0] gp_combine(input logic g_hi, input logic p_hi,
                                            input logic g_lo, input logic p_lo);
    return {g_hi | (p_hi & g_lo), p_hi & p_lo};
  endfunction
endpackage

// File: rtl/bk_bitgen.sv
module bk_bitgen
  import bk_adder_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] tg_o,
  output logic [W-1:0] tp_o
);
  assign p_o = a_i ^ b_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_fold
      // carry-in as a virtual stage below bit 0: g = cin, p = 0
      assign {tg_o[i], tp_o[i]} = gp_combine(a_i[i] & b_i[i], a_i[i] ^ b_i[i], cin_i, 1'b0);
    end else begin : g_plain
      assign tg_o[i] = a_i[i] & b_i[i];
      assign tp_o[i] = a_i[i] ^ b_i[i];
    end
  end
endmodule

// File: rtl/bk_prefix_net.sv
module bk_prefix_net
  import bk_adder_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] c_o
);
  localparam int unsigned LEVELS = $clog2(W);

  // up-sweep: level l combines nodes whose span is 2^l
  for (genvar l = 0; l <= LEVELS; l++) begin : up_lvl
    logic [W-1:0] g;
    logic [W-1:0] p;
    if (l == 0) begin : g_src
      assign g = g_i;
      assign p = p_i;
    end else begin : g_red
      localparam int unsigned SPAN = 1 << l;
      localparam int unsigned HALF = SPAN / 2;
      for (genvar i = 0; i < W; i++) begin : g_node
        if (((i + 1) % SPAN) == 0) begin : g_cell
          assign {g[i], p[i]} = gp_combine(up_lvl[l-1].g[i], up_lvl[l-1].p[i],
                                           up_lvl[l-1].g[i-HALF], up_lvl[l-1].p[i-HALF]);
        end else begin : g_wire
          assign g[i] = up_lvl[l-1].g[i];
          assign p[i] = up_lvl[l-1].p[i];
        end
      end
    end
  end

  // down-sweep: fill in the midpoints, widest span first
  for (genvar d = 0; d < LEVELS; d++) begin : dn_lvl
    logic [W-1:0] g;
    logic [W-1:0] p;
    if (d == 0) begin : g_src
      assign g = up_lvl[LEVELS].g;
      assign p = up_lvl[LEVELS].p;
    end else begin : g_fill
      localparam int unsigned SPAN = 1 << (LEVELS - d);
      localparam int unsigned HALF = SPAN / 2;
      for (genvar i = 0; i < W; i++) begin : g_node
        if ((((i + 1) % SPAN) == HALF) && (i >= SPAN)) begin : g_cell
          assign {g[i], p[i]} = gp_combine(dn_lvl[d-1].g[i], dn_lvl[d-1].p[i],
                                           dn_lvl[d-1].g[i-HALF], dn_lvl[d-1].p[i-HALF]);
        end else begin : g_wire
          assign g[i] = dn_lvl[d-1].g[i];
          assign p[i] = dn_lvl[d-1].p[i];
        end
      end
    end
  end

  assign c_o = dn_lvl[LEVELS-1].g;

  always_comb begin
    if (!$isunknown({g_i, p_i, c_o})) begin
      for (int i = 0; i < W; i++) begin
        AST_CARRY_SOURCE: assert (!c_o[i] || g_i[i] || p_i[i])
          else $error("carry out of %0d with neither generate nor propagate", i); // R6
      end
      AST_ROOT_PROPAGATE: assert (up_lvl[LEVELS].p[W-1] == (&p_i))
        else $error("root group propagate mismatch"); // R4
    end
  end
endmodule

// File: rtl/bk_sum.sv
module bk_sum #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] c_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] c_into;

  // carry into bit i is the prefix carry out of bit i-1
  assign c_into = {c_i[W-2:0], cin_i};
  assign sum_o  = p_i ^ c_into;
  assign cout_o = c_i[W-1];
endmodule

// File: rtl/bk_adder.sv
module bk_adder #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned RW = WIDTH + 1;

  logic [WIDTH-1:0] p_raw;
  logic [WIDTH-1:0] tg;
  logic [WIDTH-1:0] tp;
  logic [WIDTH-1:0] carry;

  bk_bitgen #(.W(WIDTH)) u_bitgen (
    .a_i  (a_i),
    .b_i  (b_i),
    .cin_i(cin_i),
    .p_o  (p_raw),
    .tg_o (tg),
    .tp_o (tp)
  );

  bk_prefix_net #(.W(WIDTH)) u_net (
    .g_i(tg),
    .p_i(tp),
    .c_o(carry)
  );

  bk_sum #(.W(WIDTH)) u_sum (
    .p_i   (p_raw),
    .c_i   (carry),
    .cin_i (cin_i),
    .sum_o (sum_o),
    .cout_o(cout_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i, sum_o, cout_o})) begin
      AST_ADD_RESULT: assert ({cout_o, sum_o} == (RW'(a_i) + RW'(b_i) + RW'(cin_i)))
        else $error("sum/carry mismatch"); // R1
      if ((a_i ^ b_i) == '1) begin
        AST_FULL_PROPAGATE: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}})
          else $error("full-width propagate failed"); // R4
      end
      if (a_i[WIDTH-1] && b_i[WIDTH-1]) begin
        AST_MSB_GENERATE: assert (cout_o)
          else $error("msb generate lost"); // R5
      end
    end
  end
endmodule

// File: tb/sim_bk_adder.sv
module sim_bk_adder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bk_adder #(.WIDTH(16)) u0 (
    .a_i   (a),
    .b_i   (b),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y,
                                          input logic c);
    int unsigned r;
    r = int'(x) + int'(y) + int'(c);
    return r[16:0];
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%0b actual=%0b expected=%0b", req, a, b, cin, act, exp);
    end
  endtask

  task automatic check_word(input logic [15:0] act, input logic [15:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%0b actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  // drive away from the edge, sample once settled
  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input string req);
    logic [16:0] e;
    @(negedge clk);
    a = x; b = y; cin = c;
    #1;
    e = ref_add(x, y, c);
    check_word(sum, e[15:0], {req, " R1 sum"});
    check_bit(cout, e[16], {req, " R2 cout"});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 195000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected<=195000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] seed;
    a = '0; b = '0; cin = 1'b0;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // zero inputs after reset: outputs at rest
    #1;
    check_word(sum, 16'h0000, "R1 idle sum");
    check_bit(cout, 1'b0, "R2 idle cout");

    // R3 carry-in alone
    apply(16'h0000, 16'h0000, 1'b1, "R3");
    check_word(sum, 16'h0001, "R3 sum is one");
    // R4 full-width propagate, both carry-ins
    apply(16'hA5C3, 16'h5A3C, 1'b1, "R4");
    check_word(sum, 16'h0000, "R4 cin=1 sum");
    check_bit(cout, 1'b1, "R4 cin=1 cout");
    apply(16'hA5C3, 16'h5A3C, 1'b0, "R4");
    check_word(sum, 16'hFFFF, "R4 cin=0 sum");
    check_bit(cout, 1'b0, "R4 cin=0 cout");
    // R5 msb generate
    apply(16'h8000, 16'h8000, 1'b0, "R5");
    check_bit(cout, 1'b1, "R5 msb cout");
    // R6 carry from bit 0 across all bits
    apply(16'hFFFF, 16'h0001, 1'b0, "R6");
    check_word(sum, 16'h0000, "R6 sum");
    check_bit(cout, 1'b1, "R6 cout");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones");
    // R7 result depends only on present inputs: back-to-back opposites
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R7 prev");
    apply(16'h0000, 16'h0000, 1'b0, "R7 next");
    check_word(sum, 16'h0000, "R7 no memory");

    // exhaustive byte slices: low byte with cin=0, high byte fed by a carry across bit 8
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        apply({8'h00, 8'(ai)}, {8'h00, 8'(bi)}, 1'b0, "slice lo");
        apply({8'(ai), 8'hFF}, {8'(bi), 8'h00}, 1'b1, "slice hi");
      end
    end

    // random full-width vectors, both carry-ins
    for (int k = 0; k < 2000; k++) begin
      apply(16'($urandom), 16'($urandom), 1'(k), "random");
    end

    finish_run();
  end
endmodule